// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a memory device. A four-wire serial interface (test clock, mode select, serial data in, serial data out) walks a sixteen-state controller. Through it an instruction is loaded, and the instruction decides which data register sits between serial input and serial output. Four data paths exist. A one-bit skip register shortens the chain when the device is not under test. A 32-bit identity word can be read back. A boundary chain can sample the device pins or drive them.

The boundary chain has two stages. The shift stage captures the pin values and shifts them out. The hold stage takes the shifted pattern at the end of a data scan. Two cells of the chain are internal. One cell enables the output drivers. While the external-test instruction is current, the hold copy of that cell alone decides whether the data outputs drive. Its reset value is 0, so entering external test without a preload leaves the outputs off. The other internal cell is preset to 1.

Serial output is retimed on the falling test-clock edge. It is enabled only while an instruction or data register is being shifted.

Top module: `bscan_tap`

## Requirements
- R1: From any state, five consecutive rising edges with `tms` high put the controller into Test-Logic-Reset. This reselects the identity instruction. `rst_n` low at a rising edge has the same effect.
- R2: State sequencing follows the standard sixteen-state diagram. A data scan may leave Shift-DR through Exit1-DR, Pause-DR and Exit2-DR and return to Shift-DR without losing or repeating bits.
- R3: In Capture-IR the instruction shift register is loaded with binary 001. The first bit shifted out is 1, the second is 0 and the third is 0.
- R4: Instruction code 001 (identity) is current after reset. With it, a data scan captures `ID_VALUE` and shifts it out least significant bit first. Bit 0 of that value is 1.
- R5: Code 111 (skip) and every code not otherwise assigned (011, 100, 101, 110) select the one-bit skip register. It captures 0, so an N-bit data scan returns a zero followed by the first N-1 input bits.
- R6: Under code 010 (sample) or code 000 (external test), Capture-DR loads the chain as follows:
  - bits 9..0 take `pin_sample`;
  - bit 10 takes the current hold copy of the driver-enable cell;
  - bit 11 takes 1.
  The chain is shifted out least significant bit first. Update-DR copies the shifted pattern to `bsr_upd`.
- R7: While code 000 is current, `pad_oe` equals `bsr_upd[10]` and ignores `core_oe`. Under every other code, `pad_oe` follows `core_oe`.
- R8: `tdo` changes only on falling `tck` edges. `tdo_en` is 1 exactly while the controller is in Shift-IR or Shift-DR. `tdo` reads 0 otherwise.
- R9: After `rst_n`, `bsr_upd` is 0x800. The current instruction changes only in Update-IR or Test-Logic-Reset. Shifting a new code therefore leaves `pad_oe` unchanged until Update-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled on rising `tck` |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| pin_sample | input | PIN_N | Device pin values captured into the boundary chain |
| core_oe | input | 1 | Output-driver enable requested by the functional logic |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| tdo_en | output | 1 | Serial output driver enable |
| pad_oe | output | 1 | Final output-driver enable for the data pins |
| bsr_upd | output | PIN_N+2 | Hold stage of the boundary chain |

## Verification
A wrong controller state shows on `tdo_en` at the next falling edge. A wrong decode shows on `pad_oe` in the same cycle as Update-IR. The reference model steps the controller and every register each cycle, so a misrouted transition or a shift by the wrong amount is reported within one clock. A capture fault, such as a wrong Capture-IR pattern, a wrong identity word or a wrong internal-cell value, appears in the bits returned by the following scan. Those bits are compared whole against values built from the requirements.

// File: rtl/bscan_pkg.sv
// Shared types and instruction codes for the boundary-scan test port.
// Assumes a 3-bit instruction register; codes not listed act as skip.
package bscan_pkg;
    localparam int IR_W = 3;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SHIFT_DR, TS_EXIT1_DR, TS_PAUSE_DR, TS_EXIT2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SHIFT_IR, TS_EXIT1_IR, TS_PAUSE_IR, TS_EXIT2_IR, TS_UPD_IR
    } tap_state_t;

    localparam logic [IR_W-1:0] OP_EXTEST = '0;
    localparam logic [IR_W-1:0] OP_IDCODE = IR_W'(1);
    localparam logic [IR_W-1:0] OP_SAMPLE = IR_W'(2);
    localparam logic [IR_W-1:0] OP_BYPASS = '1;
    localparam logic [IR_W-1:0] IR_CAPT   = IR_W'(1);
endpackage

// File: rtl/bscan_fsm.sv
// Sixteen-state test controller. Advances on rising tck.
// Assumes rst_n is synchronous to tck.
module bscan_fsm
    import bscan_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_t state
);
    localparam int RESET_RUN = 5;

    tap_state_t nxt;

    // Next state from the current state and tms.
    always_comb begin
        case (state)
            TS_RESET:    nxt = tms ? TS_RESET    : TS_IDLE;
            TS_IDLE:     nxt = tms ? TS_SEL_DR   : TS_IDLE;
            TS_SEL_DR:   nxt = tms ? TS_SEL_IR   : TS_CAP_DR;
            TS_CAP_DR:   nxt = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
            TS_SHIFT_DR: nxt = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
            TS_EXIT1_DR: nxt = tms ? TS_UPD_DR   : TS_PAUSE_DR;
            TS_PAUSE_DR: nxt = tms ? TS_EXIT2_DR : TS_PAUSE_DR;
            TS_EXIT2_DR: nxt = tms ? TS_UPD_DR   : TS_SHIFT_DR;
            TS_UPD_DR:   nxt = tms ? TS_SEL_DR   : TS_IDLE;
            TS_SEL_IR:   nxt = tms ? TS_RESET    : TS_CAP_IR;
            TS_CAP_IR:   nxt = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
            TS_SHIFT_IR: nxt = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
            TS_EXIT1_IR: nxt = tms ? TS_UPD_IR   : TS_PAUSE_IR;
            TS_PAUSE_IR: nxt = tms ? TS_EXIT2_IR : TS_PAUSE_IR;
            TS_EXIT2_IR: nxt = tms ? TS_UPD_IR   : TS_SHIFT_IR;
            TS_UPD_IR:   nxt = tms ? TS_SEL_DR   : TS_IDLE;
            default:     nxt = TS_RESET;
        endcase
    end

    // State register.
    always_ff @(posedge tck) begin
        if (!rst_n) state <= TS_RESET;
        else        state <= nxt;
    end

    // Checker: counts consecutive tms-high edges, saturating at RESET_RUN.
    logic [$clog2(RESET_RUN+1)-1:0] hi_run;
    always_ff @(posedge tck) begin
        if (!rst_n)                                   hi_run <= '0;
        else if (!tms)                                hi_run <= '0;
        else if (hi_run != ($bits(hi_run))'(RESET_RUN)) hi_run <= hi_run + 1'b1;
    end

    assert_five_ones_reset_R1: assert property (@(posedge tck) disable iff (!rst_n)
        (hi_run == ($bits(hi_run))'(RESET_RUN)) |-> (state == TS_RESET));

    assert_pause_returns_shift_R2: assert property (@(posedge tck) disable iff (!rst_n)
        (state == TS_EXIT2_DR && !tms) |=> (state == TS_SHIFT_DR));
endmodule

// File: rtl/bscan_ir.sv
// Instruction register: a shift stage, plus the current instruction loaded
// at Update-IR. Test-Logic-Reset selects the identity instruction.
module bscan_ir
    import bscan_pkg::*;
(
    input  logic            tck,
    input  logic            rst_n,
    input  tap_state_t      state,
    input  logic            tdi,
    output logic            ir_lsb,
    output logic [IR_W-1:0] instr
);
    logic [IR_W-1:0] ir_sr;

    // Shift stage: capture the fixed pattern, then shift toward bit 0.
    always_ff @(posedge tck) begin
        if (!rst_n)                   ir_sr <= '0;
        else if (state == TS_CAP_IR)  ir_sr <= IR_CAPT;
        else if (state == TS_SHIFT_IR) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // Current instruction: identity on reset, shifted code on Update-IR.
    always_ff @(posedge tck) begin
        if (!rst_n || state == TS_RESET) instr <= OP_IDCODE;
        else if (state == TS_UPD_IR)     instr <= ir_sr;
    end

    assign ir_lsb = ir_sr[0];

    assert_capture_pattern_R3: assert property (@(posedge tck) disable iff (!rst_n)
        (state == TS_CAP_IR) |=> (ir_sr[1:0] == 2'b01));

    assert_reset_selects_id_R4: assert property (@(posedge tck) disable iff (!rst_n)
        (state == TS_RESET) |=> (instr == OP_IDCODE));

    assert_instr_holds_R9: assert property (@(posedge tck) disable iff (!rst_n)
        (state != TS_UPD_IR && state != TS_RESET) |=> $stable(instr));
endmodule

// File: rtl/bscan_bsr.sv
// Boundary chain: PIN_N pin cells, then the driver-enable cell, then a
// preset cell. The hold stage changes only at Update-DR while selected.
// The driver-enable cell captures its own hold copy; the preset cell captures 1.
module bscan_bsr
    import bscan_pkg::*;
#(
    parameter int PIN_N = 10
) (
    input  logic               tck,
    input  logic               rst_n,
    input  tap_state_t         state,
    input  logic               tdi,
    input  logic               sel,
    input  logic               extest,
    input  logic [PIN_N-1:0]   pin_sample,
    input  logic               core_oe,
    output logic               bsr_lsb,
    output logic [PIN_N+1:0]   bsr_upd,
    output logic               pad_oe
);
    localparam int BSR_LEN    = PIN_N + 2;
    localparam int OE_BIT     = PIN_N;
    localparam int PRESET_BIT = PIN_N + 1;
    localparam logic [BSR_LEN-1:0] RST_VAL = BSR_LEN'(1) << PRESET_BIT;

    logic [BSR_LEN-1:0] sr;

    // Shift stage: capture pins and internal cells, then shift toward bit 0.
    always_ff @(posedge tck) begin
        if (!rst_n)                            sr <= RST_VAL;
        else if (sel && state == TS_CAP_DR)    sr <= {1'b1, bsr_upd[OE_BIT], pin_sample};
        else if (sel && state == TS_SHIFT_DR)  sr <= {tdi, sr[BSR_LEN-1:1]};
    end

    // Hold stage: takes the shifted pattern at Update-DR.
    always_ff @(posedge tck) begin
        if (!rst_n)                         bsr_upd <= RST_VAL;
        else if (sel && state == TS_UPD_DR) bsr_upd <= sr;
    end

    // Under external test the driver-enable cell overrides the core request.
    assign pad_oe  = extest ? bsr_upd[OE_BIT] : core_oe;
    assign bsr_lsb = sr[0];

    assert_update_copies_R6: assert property (@(posedge tck) disable iff (!rst_n)
        (sel && state == TS_UPD_DR) |=> (bsr_upd == $past(sr)));

    assert_extest_oe_cell_R7: assert property (@(posedge tck) disable iff (!rst_n)
        (extest && state == TS_UPD_DR) |=> (pad_oe == $past(sr[OE_BIT])));
endmodule

// File: rtl/bscan_tap.sv
// Top of the test port: controller, instruction register, skip bit,
// identity register, boundary chain and falling-edge serial output.
// Assumes tck is free-running while rst_n is low.
module bscan_tap
    import bscan_pkg::*;
#(
    parameter int               PIN_N    = 10,
    parameter int               ID_W     = 32,
    parameter logic [ID_W-1:0]  ID_VALUE = 32'h2B9D_6071
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             tms,
    input  logic             tdi,
    input  logic [PIN_N-1:0] pin_sample,
    input  logic             core_oe,
    output logic             tdo,
    output logic             tdo_en,
    output logic             pad_oe,
    output logic [PIN_N+1:0] bsr_upd
);
    tap_state_t      state;
    logic [IR_W-1:0] instr;
    logic            ir_lsb, bsr_lsb;
    logic            sel_bsr, sel_id, sel_byp, is_extest;
    logic            byp_q;
    logic [ID_W-1:0] id_sr;
    logic            dr_lsb;

    bscan_fsm i_fsm (.tck(tck), .rst_n(rst_n), .tms(tms), .state(state));

    bscan_ir i_ir (.tck(tck), .rst_n(rst_n), .state(state), .tdi(tdi),
                   .ir_lsb(ir_lsb), .instr(instr));

    // Decode: the chain for sample and external test, identity, else skip.
    always_comb begin
        is_extest = (instr == OP_EXTEST);
        sel_bsr   = is_extest || (instr == OP_SAMPLE);
        sel_id    = (instr == OP_IDCODE);
        sel_byp   = !sel_bsr && !sel_id;
    end

    bscan_bsr #(.PIN_N(PIN_N)) i_bsr (
        .tck(tck), .rst_n(rst_n), .state(state), .tdi(tdi),
        .sel(sel_bsr), .extest(is_extest), .pin_sample(pin_sample),
        .core_oe(core_oe), .bsr_lsb(bsr_lsb), .bsr_upd(bsr_upd), .pad_oe(pad_oe));

    // Skip register: captures 0, then passes tdi through one stage.
    always_ff @(posedge tck) begin
        if (!rst_n)                             byp_q <= 1'b0;
        else if (sel_byp && state == TS_CAP_DR) byp_q <= 1'b0;
        else if (sel_byp && state == TS_SHIFT_DR) byp_q <= tdi;
    end

    // Identity register: captures the fixed word, then shifts toward bit 0.
    always_ff @(posedge tck) begin
        if (!rst_n)                              id_sr <= ID_VALUE;
        else if (sel_id && state == TS_CAP_DR)   id_sr <= ID_VALUE;
        else if (sel_id && state == TS_SHIFT_DR) id_sr <= {tdi, id_sr[ID_W-1:1]};
    end

    // Selected data-register output bit.
    always_comb begin
        if (sel_bsr)     dr_lsb = bsr_lsb;
        else if (sel_id) dr_lsb = id_sr[0];
        else             dr_lsb = byp_q;
    end

    // Serial output retimed on the falling edge; enabled only while shifting.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else if (state == TS_SHIFT_IR) begin
            tdo    <= ir_lsb;
            tdo_en <= 1'b1;
        end else if (state == TS_SHIFT_DR) begin
            tdo    <= dr_lsb;
            tdo_en <= 1'b1;
        end else begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end
    end

    assert_skip_captures_zero_R5: assert property (@(posedge tck) disable iff (!rst_n)
        (sel_byp && state == TS_CAP_DR) |=> (byp_q == 1'b0));

    assert_id_capture_R4: assert property (@(posedge tck) disable iff (!rst_n)
        (sel_id && state == TS_CAP_DR) |=> (id_sr == ID_VALUE));
endmodule

// File: tb/test_bscan_tap.sv
module test_bscan_tap;
    import bscan_pkg::*;

    localparam int          PIN_N = 10;
    localparam int          BL    = PIN_N + 2;
    localparam logic [31:0] IDV   = 32'h2B9D_6071;

    // Reference-model state numbering, in diagram order.
    localparam int S_RST = 0, S_IDL = 1, S_SDR = 2, S_CDR = 3, S_SHDR = 4, S_E1DR = 5,
                   S_PDR = 6, S_E2DR = 7, S_UDR = 8, S_SIR = 9, S_CIR = 10, S_SHIR = 11,
                   S_E1IR = 12, S_PIR = 13, S_E2IR = 14, S_UIR = 15;

    logic tck = 1'b0, rst_n = 1'b0, tms = 1'b0, tdi = 1'b0, core_oe = 1'b1;
    logic [PIN_N-1:0] pin_sample = '0;
    logic tdo, tdo_en, pad_oe;
    logic [BL-1:0] bsr_upd;

    int ncheck = 0, nfail = 0;
    bit done = 0;

    // Reference model.
    int m_st = S_RST;
    logic [2:0] m_ir = '0, m_instr = 3'b001;
    logic m_byp = 1'b0, m_tdo = 1'b0, m_en = 1'b0;
    logic [31:0] m_id = IDV;
    logic [BL-1:0] m_bsr = 12'h800, m_upd = 12'h800;
    logic last_tdo = 1'b0, pre_upd_oe = 1'b0;

    always #10 tck = ~tck;

    bscan_tap #(.PIN_N(PIN_N), .ID_W(32), .ID_VALUE(IDV)) i_bscan_tap (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .pin_sample(pin_sample),
        .core_oe(core_oe), .tdo(tdo), .tdo_en(tdo_en), .pad_oe(pad_oe), .bsr_upd(bsr_upd));

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        ncheck++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int next_st(input int s, input logic m);
        case (s)
            S_RST:  return m ? S_RST  : S_IDL;
            S_IDL:  return m ? S_SDR  : S_IDL;
            S_SDR:  return m ? S_SIR  : S_CDR;
            S_CDR:  return m ? S_E1DR : S_SHDR;
            S_SHDR: return m ? S_E1DR : S_SHDR;
            S_E1DR: return m ? S_UDR  : S_PDR;
            S_PDR:  return m ? S_E2DR : S_PDR;
            S_E2DR: return m ? S_UDR  : S_SHDR;
            S_UDR:  return m ? S_SDR  : S_IDL;
            S_SIR:  return m ? S_RST  : S_CIR;
            S_CIR:  return m ? S_E1IR : S_SHIR;
            S_SHIR: return m ? S_E1IR : S_SHIR;
            S_E1IR: return m ? S_UIR  : S_PIR;
            S_PIR:  return m ? S_E2IR : S_PIR;
            S_E2IR: return m ? S_UIR  : S_SHIR;
            default: return m ? S_SDR : S_IDL;
        endcase
    endfunction

    function automatic int m_sel();
        if (m_instr == 3'b000 || m_instr == 3'b010) return 2;
        if (m_instr == 3'b001) return 1;
        return 0;
    endfunction

    // One tck cycle: drive, advance model at the rising edge, compare after the falling edge.
    task automatic step(input logic t_ms, input logic t_di);
        logic exp_oe;
        tms = t_ms;
        tdi = t_di;
        @(posedge tck);
        if (!rst_n) begin
            m_st = S_RST; m_ir = '0; m_instr = 3'b001; m_byp = 0;
            m_id = IDV; m_bsr = 12'h800; m_upd = 12'h800;
        end else begin
            case (m_st)
                S_RST:  m_instr = 3'b001;
                S_CIR:  m_ir = 3'b001;
                S_SHIR: m_ir = {tdi, m_ir[2:1]};
                S_UIR:  m_instr = m_ir;
                S_CDR: case (m_sel())
                           2: m_bsr = {1'b1, m_upd[PIN_N], pin_sample};
                           1: m_id = IDV;
                           default: m_byp = 1'b0;
                       endcase
                S_SHDR: case (m_sel())
                           2: m_bsr = {tdi, m_bsr[BL-1:1]};
                           1: m_id = {tdi, m_id[31:1]};
                           default: m_byp = tdi;
                        endcase
                S_UDR: if (m_sel() == 2) m_upd = m_bsr;
                default: ;
            endcase
            m_st = next_st(m_st, tms);
        end
        @(negedge tck);
        #5;
        m_en = (m_st == S_SHIR || m_st == S_SHDR);
        if (m_st == S_SHIR) m_tdo = m_ir[0];
        else if (m_st == S_SHDR) m_tdo = (m_sel() == 2) ? m_bsr[0] : (m_sel() == 1) ? m_id[0] : m_byp;
        else m_tdo = 1'b0;
        exp_oe = (m_instr == 3'b000) ? m_upd[PIN_N] : core_oe;
        chk(tdo_en === m_en, "R8", "tdo_en per cycle", 64'(tdo_en), 64'(m_en));
        chk(tdo === m_tdo, "R8", "tdo per cycle", 64'(tdo), 64'(m_tdo));
        chk(pad_oe === exp_oe, "R7", "pad_oe per cycle", 64'(pad_oe), 64'(exp_oe));
        chk(bsr_upd === m_upd, "R9", "bsr_upd per cycle", 64'(bsr_upd), 64'(m_upd));
        last_tdo = tdo;
    endtask

    // Instruction scan from Run-Test/Idle, back to Run-Test/Idle.
    task automatic scan_ir(input logic [2:0] code, output logic [2:0] dout);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 3; i++) begin
            dout[i] = last_tdo;
            step(i == 2, code[i]);
        end
        pre_upd_oe = pad_oe;
        step(1, 0); step(0, 0);
    endtask

    // Data scan from Run-Test/Idle, optionally pausing halfway.
    task automatic scan_dr(input logic [63:0] din, input int len,
                           output logic [63:0] dout, input bit pause_mid);
        dout = '0;
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < len; i++) begin
            dout[i] = last_tdo;
            if (pause_mid && i == len / 2) begin
                step(1, din[i]); step(0, 0); step(1, 0); step(0, 0);
            end else begin
                step(i == len - 1, din[i]);
            end
        end
        step(1, 0); step(0, 0);
    endtask

    initial begin
        logic [2:0]  iro;
        logic [63:0] dro;
        logic [BL-1:0] pat;

        // Reset state.
        step(0, 0); step(0, 0); step(0, 0);
        rst_n = 1'b1;
        chk(tdo_en === 1'b0, "R8", "tdo_en after reset", 64'(tdo_en), 64'(0));
        chk(pad_oe === core_oe, "R7", "pad_oe after reset", 64'(pad_oe), 64'(core_oe));
        chk(bsr_upd === 12'h800, "R9", "bsr_upd reset value", 64'(bsr_upd), 64'h800);
        step(0, 0);

        // R4: identity selected after reset.
        scan_dr(64'h0, 32, dro, 0);
        chk(dro[31:0] === IDV, "R4", "identity word", dro, 64'(IDV));
        chk(dro[0] === 1'b1, "R4", "identity lsb", 64'(dro[0]), 64'(1));

        // R2: scan broken by Pause-DR returns the same word.
        scan_dr(64'h0, 32, dro, 1);
        chk(dro[31:0] === IDV, "R2", "identity through pause", dro, 64'(IDV));

        // R3: capture pattern seen while loading skip.
        scan_ir(3'b111, iro);
        chk(iro === 3'b001, "R3", "capture-IR bits", 64'(iro), 64'(3'b001));

        // R5: skip register, code 111.
        scan_dr(64'hB4, 8, dro, 0);
        chk(dro[7:0] === 8'h68, "R5", "skip code 111 delay", dro, 64'h68);

        // R5: unassigned code 101 acts as skip.
        scan_ir(3'b101, iro);
        chk(iro === 3'b001, "R3", "capture-IR bits again", 64'(iro), 64'(3'b001));
        scan_dr(64'h3C, 8, dro, 0);
        chk(dro[7:0] === 8'h78, "R5", "unused code 101 delay", dro, 64'h78);

        // R6: sample captures pins and internal cells, update loads hold stage.
        pin_sample = 10'h2A5;
        core_oe = 1'b1;
        scan_ir(3'b010, iro);
        pat = {1'b1, 1'b1, 10'h0F0};
        scan_dr(64'(pat), BL, dro, 0);
        chk(dro[BL-1:0] === {1'b1, 1'b0, 10'h2A5}, "R6", "sample capture",
            dro, 64'({1'b1, 1'b0, 10'h2A5}));
        chk(bsr_upd === pat, "R6", "sample update", 64'(bsr_upd), 64'(pat));
        chk(pad_oe === 1'b1, "R7", "sample keeps core enable", 64'(pad_oe), 64'(1));
        core_oe = 1'b0;
        step(0, 0);
        chk(pad_oe === 1'b0, "R7", "sample follows core enable", 64'(pad_oe), 64'(0));

        // R9 then R7: new code takes effect only at Update-IR.
        scan_ir(3'b000, iro);
        chk(pre_upd_oe === 1'b0, "R9", "pad_oe before Update-IR", 64'(pre_upd_oe), 64'(0));
        chk(pad_oe === 1'b1, "R7", "extest uses enable cell", 64'(pad_oe), 64'(1));
        core_oe = 1'b1;
        pin_sample = 10'h15A;
        pat = {1'b1, 1'b0, 10'h3FF};
        scan_dr(64'(pat), BL, dro, 0);
        chk(dro[BL-1:0] === {1'b1, 1'b1, 10'h15A}, "R6", "extest capture",
            dro, 64'({1'b1, 1'b1, 10'h15A}));
        chk(pad_oe === 1'b0, "R7", "extest forces drivers off", 64'(pad_oe), 64'(0));

        // R1: five tms-high edges return to reset and identity.
        for (int k = 0; k < 5; k++) step(1, 0);
        chk(pad_oe === 1'b1, "R1", "reset leaves extest", 64'(pad_oe), 64'(1));
        step(0, 0);
        scan_dr(64'h0, 32, dro, 0);
        chk(dro[31:0] === IDV, "R1", "identity after tms reset", dro, 64'(IDV));

        // R1 from inside Shift-IR.
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int k = 0; k < 5; k++) step(1, 0);
        step(0, 0);
        scan_dr(64'h0, 32, dro, 0);
        chk(dro[31:0] === IDV, "R1", "identity after reset from Shift-IR", dro, 64'(IDV));

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", ncheck, nfail);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            ncheck++;
            nfail++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", ncheck, nfail);
            $finish;
        end
    end
endmodule